// File: doc/BRIEF.md
# Cyclic Key Word Subkey Mixer

This block performs the first step of expanding a cipher key into an 18-entry table of 32-bit round subkeys. The table is first filled with its initial constants through a word-wide load port. A start pulse then runs a pass that combines every table entry with one word of the key using a bitwise exclusive-or. When the key has fewer words than the table has entries, the key words are reused in a cycle. After the pass, any entry can be read through a separate read port.

The key arrives as a 448-bit vector that holds up to fourteen 32-bit words. A separate input gives the key length in words. The pass handles one table entry per clock, so its latency is fixed and does not depend on the key length. Entry `i` (counting from 0) is combined with key word `i mod L`, where `L` is the effective key length. With a full key, entries 0 to 13 take key words 0 to 13 and entries 14 to 17 take key words 0 to 3 again. The later expansion stage, which encrypts with the cipher to replace entries, belongs to a separate block. This block only produces the mixed table.

Top module: `subkey_mixer`

## Requirements
- R1: After reset, every table entry reads as zero and `done` is low.
- R2: While no pass is running, a cycle with `load_en` high writes `load_data` into entry `load_idx` when `load_idx` is below 18. A `load_idx` of 18 or more changes no entry. `rd_data` shows entry `rd_idx` combinationally.
- R3: With a key length of 14, entry `i` becomes its previous value XOR key word `i` for `i` from 0 to 13. Entries 14 to 17 are XORed with key words 0 to 3.
- R4: With a key length `L` from 1 to 13, entry `i` becomes its previous value XOR key word `i mod L`.
- R5: A key length of 0, or any value above 14 (the field is 4 bits wide), is treated as 14.
- R6: Key word 0 is `key_in[447:416]`. Key word `k` is `key_in[447-32k -: 32]`. `key_in` and `key_len` must be held steady for the whole pass. `key_len` is sampled on the start edge.
- R7: If `start` is sampled high on clock edge k while idle, `done` is high for exactly one cycle, the cycle that follows edge k+18. It is low at all other times.
- R8: While a pass is running, `start` and `load_en` are ignored. The pass finishes on its original schedule and with its original result.
- R9: Running a second pass with the same key and length returns every entry to its value before the first pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 448 | Key, word 0 in the most significant 32 bits |
| key_len | input | 4 | Key length in 32-bit words; 0 or above 14 means 14 |
| load_en | input | 1 | Write strobe for the initial table constants |
| load_idx | input | 5 | Entry addressed by the load |
| load_data | input | 32 | Constant written by the load |
| start | input | 1 | Begins a mixing pass when idle |
| done | output | 1 | One-cycle pulse when the pass completes |
| rd_idx | input | 5 | Entry addressed by the read port |
| rd_data | output | 32 | Contents of entry `rd_idx` (zero when out of range) |

## Verification
The internal state is a cycle counter, a wrapping key-word selector and the latched effective length. If the selector goes wrong, it picks the wrong key word from the first entry where it strays. That error stays in the table and shows on a read-back right after `done`. A length that was clamped wrongly or sampled late shows up on entries at or beyond the first point of wrap-around. A counter that miscounts moves the `done` pulse away from the cycle after edge k+18, and the bench measures this against every pass. Disturbing the block during a pass shows up either in that timing or in the entry that was addressed during the pass.

// File: rtl/kmix_pkg.sv
`timescale 1ns/1ps
package kmix_pkg;

   typedef enum logic {
      KM_IDLE = 1'b0,
      KM_MIX  = 1'b1
   } km_state_e;

   localparam int KM_WORD_W = 32;

endpackage

// File: rtl/kmix_keysel.sv
`timescale 1ns/1ps
module kmix_keysel #(
   parameter int WORD_W    = 32,
   parameter int KEY_WORDS = 14,
   parameter int SEL_W     = 4
) (
   input  logic [KEY_WORDS*WORD_W-1:0] key_vec,
   input  logic [SEL_W-1:0]            sel,
   output logic [WORD_W-1:0]           word
);

   logic [WORD_W-1:0] kw [KEY_WORDS];

   // word 0 is the most significant slice of the key vector
   for (genvar g = 0; g < KEY_WORDS; g++) begin : g_slice
      assign kw[g] = key_vec[(KEY_WORDS-g)*WORD_W-1 -: WORD_W];
   end

   always_comb begin
      word = '0;
      for (int i = 0; i < KEY_WORDS; i++) begin
         if (SEL_W'(i) == sel) word = kw[i];
      end
   end

endmodule

// File: rtl/kmix_seq.sv
`timescale 1ns/1ps
module kmix_seq
   import kmix_pkg::*;
#(
   parameter int ENTRIES   = 18,
   parameter int KEY_WORDS = 14,
   parameter int IDX_W     = 5,
   parameter int SEL_W     = 4,
   parameter int LEN_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] key_len,
   output logic             run,
   output logic [IDX_W-1:0] ent,
   output logic [SEL_W-1:0] ksel,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_ENT = IDX_W'(ENTRIES - 1);
   localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(KEY_WORDS);

   km_state_e        state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_eff;
   logic             wrap;

   always_comb begin
      if (key_len == '0 || key_len > MAX_LEN) len_eff = MAX_LEN;
      else                                    len_eff = key_len;
   end

   assign wrap = (LEN_W'(ksel) == len_q - LEN_W'(1));
   assign run  = (state_q == KM_MIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KM_IDLE;
         ent     <= '0;
         ksel    <= '0;
         len_q   <= MAX_LEN;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            KM_IDLE: begin
               if (start) begin
                  state_q <= KM_MIX;
                  ent     <= '0;
                  ksel    <= '0;
                  len_q   <= len_eff;
               end
            end
            KM_MIX: begin
               if (ent == LAST_ENT) begin
                  state_q <= KM_IDLE;
                  done    <= 1'b1;
               end else begin
                  ent  <= ent + IDX_W'(1);
                  ksel <= wrap ? '0 : ksel + SEL_W'(1);
               end
            end
            default: state_q <= KM_IDLE;
         endcase
      end
   end

   p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (len_q != '0 && len_q <= MAX_LEN));

   p_ksel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (LEN_W'(ksel) < len_q));

   p_ent_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ent <= LAST_ENT));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(run) && $past(ent) == LAST_ENT));

   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start && ent != LAST_ENT) |=> (run && ent == $past(ent) + IDX_W'(1)));

endmodule

// File: rtl/kmix_store.sv
`timescale 1ns/1ps
module kmix_store #(
   parameter int WORD_W  = 32,
   parameter int ENTRIES = 18,
   parameter int IDX_W   = 5,
   parameter bit RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              mx_we,
   input  logic [IDX_W-1:0]  mx_idx,
   input  logic [WORD_W-1:0] mx_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [ENTRIES-1:0][WORD_W-1:0] mem;
   logic [WORD_W-1:0]              rd_sel;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    mem[g] <= '0;
         else if (mx_we && mx_idx == IDX_W'(g))         mem[g] <= mem[g] ^ mx_word;
         else if (ld_we && ld_idx == IDX_W'(g))         mem[g] <= ld_data;
      end
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (IDX_W'(i) == rd_idx) rd_sel = mem[i];
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_sel;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_sel;
   end

   p_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_we && mx_we));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_we && !mx_we) |=> $stable(mem));

   p_mix_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mx_we |-> (int'(mx_idx) < ENTRIES));

endmodule

// File: rtl/subkey_mixer.sv
`timescale 1ns/1ps
module subkey_mixer #(
   parameter int WORD_W    = 32,
   parameter int ENTRIES   = 18,
   parameter int KEY_WORDS = 14,
   parameter bit RD_REG    = 1'b0,
   localparam int KEY_W    = KEY_WORDS * WORD_W,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int SEL_W    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
   localparam int LEN_W    = $clog2(KEY_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEY_W-1:0]  key_in,
   input  logic [LEN_W-1:0]  key_len,
   input  logic              load_en,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic [WORD_W-1:0] load_data,
   input  logic              start,
   output logic              done,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("subkey_mixer: ENTRIES must be at least 2");
   end
   if (KEY_WORDS < 1 || KEY_WORDS > ENTRIES) begin : g_bad_key
      $error("subkey_mixer: KEY_WORDS must lie in 1..ENTRIES");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("subkey_mixer: WORD_W must be positive");
   end

   logic              run;
   logic [IDX_W-1:0]  ent;
   logic [SEL_W-1:0]  ksel;
   logic [WORD_W-1:0] kword;
   logic              ld_ok;

   assign ld_ok = load_en && !run && (int'(load_idx) < ENTRIES);

   kmix_seq #(
      .ENTRIES  (ENTRIES),
      .KEY_WORDS(KEY_WORDS),
      .IDX_W    (IDX_W),
      .SEL_W    (SEL_W),
      .LEN_W    (LEN_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .key_len(key_len),
      .run    (run),
      .ent    (ent),
      .ksel   (ksel),
      .done   (done)
   );

   kmix_keysel #(
      .WORD_W   (WORD_W),
      .KEY_WORDS(KEY_WORDS),
      .SEL_W    (SEL_W)
   ) u_keysel (
      .key_vec(key_in),
      .sel    (ksel),
      .word   (kword)
   );

   kmix_store #(
      .WORD_W (WORD_W),
      .ENTRIES(ENTRIES),
      .IDX_W  (IDX_W),
      .RD_REG (RD_REG)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_we  (ld_ok),
      .ld_idx (load_idx),
      .ld_data(load_data),
      .mx_we  (run),
      .mx_idx (ent),
      .mx_word(kword),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   p_load_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && load_en) |-> !u_store.ld_we);

endmodule

// File: tb/test_subkey_mixer.sv
`timescale 1ns/1ps
module test_subkey_mixer;

   localparam int NW = 18;
   localparam int KW = 14;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [447:0] key_in;
   logic [3:0]   key_len;
   logic         load_en;
   logic [4:0]   load_idx;
   logic [31:0]  load_data;
   logic         start;
   logic         done;
   logic [4:0]   rd_idx;
   logic [31:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   logic [31:0] model [NW];

   always #5 clk = ~clk;

   subkey_mixer i_subkey_mixer (
      .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_len(key_len),
      .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
      .start(start), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] kword(input logic [447:0] k, input int i);
      return k[447-32*i -: 32];
   endfunction

   function automatic logic [447:0] mk_key(input logic [31:0] seed);
      logic [447:0] k;
      for (int i = 0; i < KW; i++)
         k[447-32*i -: 32] = seed ^ (32'h0101_0101 * (i + 1)) ^ {i[7:0], 24'h5A3C71};
      return k;
   endfunction

   task automatic load_word(input logic [4:0] idx, input logic [31:0] d);
      @(negedge clk);
      load_en = 1'b1; load_idx = idx; load_data = d;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic load_all(input logic [31:0] seed);
      for (int i = 0; i < NW; i++) begin
         model[i] = seed + 32'h1357_9BDF * i;
         load_word(5'(i), model[i]);
      end
   endtask

   task automatic read_word(input int idx, output logic [31:0] d);
      rd_idx = 5'(idx);
      #1;
      d = rd_data;
   endtask

   task automatic check_array(input string req);
      logic [31:0] d;
      for (int i = 0; i < NW; i++) begin
         read_word(i, d);
         chk(d === model[i], $sformatf("%s entry %0d", req, i), d, model[i]);
      end
   endtask

   task automatic mix_model(input logic [447:0] k, input int len);
      int eff;
      eff = (len == 0 || len > KW) ? KW : len;
      for (int i = 0; i < NW; i++) model[i] = model[i] ^ kword(k, i % eff);
   endtask

   // starts a pass; checks the done pulse position (R7); optional disturbance (R8)
   task automatic run_mix(input logic [447:0] k, input int len, input bit disturb);
      @(negedge clk);
      key_in = k; key_len = 4'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= 20; c++) begin
         if (disturb && c == 5) begin
            start = 1'b1; load_en = 1'b1; load_idx = 5'd3; load_data = 32'hDEAD_BEEF;
            key_len = 4'd1;
         end
         if (disturb && c == 7) begin
            start = 1'b0; load_en = 1'b0; key_len = 4'(len);
         end
         @(negedge clk);
         chk(done === (c == 18), $sformatf("R7 done at cycle %0d", c), {31'd0, done}, {31'd0, c == 18});
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk(done === 1'b0, "R1 done low after reset", {31'd0, done}, 32'd0);
      for (int i = 0; i < NW; i++) begin
         read_word(i, d);
         chk(d === 32'd0, $sformatf("R1 entry %0d zero", i), d, 32'd0);
      end
   endtask

   task automatic t_load();
      load_all(32'h2400_0000);
      check_array("R2 load");
      load_word(5'd18, 32'hFFFF_FFFF);
      load_word(5'd31, 32'h1234_5678);
      check_array("R2 out-of-range load");
   endtask

   task automatic t_full();
      logic [447:0] k;
      k = mk_key(32'hC0DE_0001);
      load_all(32'h9A11_0000);
      run_mix(k, 14, 1'b0);
      mix_model(k, 14);
      check_array("R3 full key");
   endtask

   task automatic t_short(input int len);
      logic [447:0] k;
      k = mk_key(32'h7700_0000 + len);
      load_all(32'h0BAD_0000 + len);
      run_mix(k, len, 1'b0);
      mix_model(k, len);
      check_array($sformatf("R4 len %0d", len));
   endtask

   task automatic t_clamp(input int len);
      logic [447:0] k;
      k = mk_key(32'h5100_0000 + len);
      load_all(32'h6600_0000);
      run_mix(k, len, 1'b0);
      mix_model(k, 14);
      check_array($sformatf("R5 len %0d clamped", len));
   endtask

   task automatic t_msb();
      logic [447:0] k;
      k = '0;
      k[447:416] = 32'h8000_0001;
      load_all(32'h0000_1000);
      run_mix(k, 1, 1'b0);
      for (int i = 0; i < NW; i++) model[i] = model[i] ^ 32'h8000_0001;
      check_array("R6 key word 0 at MSB");
   endtask

   task automatic t_busy();
      logic [447:0] k;
      k = mk_key(32'hB05E_0000);
      load_all(32'h4400_0000);
      run_mix(k, 9, 1'b1);
      mix_model(k, 9);
      check_array("R8 disturbed pass");
      chk(done === 1'b0, "R8 no second pass", {31'd0, done}, 32'd0);
   endtask

   task automatic t_twice();
      logic [447:0] k;
      k = mk_key(32'h2222_0000);
      load_all(32'h3300_0000);
      run_mix(k, 11, 1'b0);
      run_mix(k, 11, 1'b0);
      check_array("R9 double pass restores");
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         fails++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; key_in = '0; key_len = 4'd0; load_en = 1'b0;
      load_idx = '0; load_data = '0; start = 1'b0; rd_idx = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_full();
      t_short(5);
      t_short(1);
      t_short(13);
      t_clamp(0);
      t_clamp(15);
      t_msb();
      t_busy();
      t_twice();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule